// File: doc/BRIEF.md
# Burst SRAM Address and Control Front End

This block is the synchronous control front end of a flow-through burst cache SRAM. It carries a small memory of 18-bit words split into two 9-bit byte lanes. On a rising clock edge it captures an address and the chip-select state when one of two address strobes is active: a processor strobe or a controller strobe. The two strobes follow different rules. From then on, a 2-bit burst counter generates the remaining addresses of a four-word burst. The counter moves only on edges where the advance input is low. A mode pin chooses between interleaved and linear order.

Reads are flow-through. The word at the current burst address appears combinationally during the cycle after the capturing edge, so a burst runs 2-1-1-1. Writes are synchronous. They are steered to byte lanes by a global write, a byte-write enable and per-lane strobes. The bus-drive indication and the read data depend on the output enable and the sleep input without waiting for a clock edge.

The block sits directly on SRAM-style pins, so there is no valid/ready handshake and no back-pressure. Every edge that meets the rules below is taken. The data bus is modelled as a read-data output together with a drive flag. The bus counts as high impedance whenever the flag is low.

Top module: `burst_sram_fe`

## Requirements
- R1: On an edge that accepts a strobe, `addr_i` is captured. In the following cycle, if that cycle is a read, `rdata` shows the word stored at that address with no further clock edge.
- R2: While a selected cycle is live, each edge with `adv_n` low and no strobe moves to the next burst word. An edge with `adv_n` high keeps the address.
- R3: With `burst_mode` = 1 (interleaved), word k of the burst (k = 0..3) uses low address bits equal to the start low bits XOR k.
- R4: With `burst_mode` = 0 (linear), word k uses low bits equal to (start low bits + k) mod 4. In both modes the upper address bits stay those that were captured.
- R5: The processor strobe `adsp_n` is ignored while `ce1_n` is high. The controller strobe `adsc_n` starts a cycle whatever `ce1_n` is. When both strobes are low and `ce1_n` is low, the processor strobe governs the edge.
- R6: A cycle is selected only if `ce1_n`=0, `ce2`=1 and `ce3_n`=0 on its start edge. A deselected cycle neither drives the bus nor writes until the next accepted strobe.
- R7: The lane mask behaves as follows. With `gw_n` low, both lanes are written. Otherwise, with `bwe_n` low, lane i is written when `bw_n[i]` is low. Otherwise no lane is written. Lane 0 is `wdata[8:0]` and lane 1 is `wdata[17:9]`.
- R8: A processor-strobe start edge never writes. A controller-strobe start edge writes the captured address. A later edge of a selected cycle writes the address that is current after that edge's advance.
- R9: A cycle that follows a writing edge does not drive the bus. A cycle of a selected burst that follows a non-writing edge is a read.
- R10: `rdata_drive` is high only for a selected read cycle with `oe_n` low and `zz` low. Changes on `oe_n` and `zz` take effect without a clock edge.
- R11: While `zz` is high, no strobe, write or advance is taken, and `rdata_drive` is low. Stored words and the burst position are kept, so reads resume unchanged once `zz` falls.
- R12: `rdata` is zero whenever `rdata_drive` is low. While `rst_n` is low, no cycle is live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of cycle state |
| addr_i | input | ADDR_W | Word address captured on an accepted strobe |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Primary chip enable, active low, also qualifies adsp_n |
| ce2 | input | 1 | Expansion chip enable, active high |
| ce3_n | input | 1 | Expansion chip enable, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write strobes, active low |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| zz | input | 1 | Sleep, active high, asynchronous on outputs |
| burst_mode | input | 1 | 1 interleaved order, 0 linear order |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_drive | output | 1 | High when the data bus is driven |

## Verification
The embedded assertions check on every cycle the following properties: a writing edge is followed by an undriven cycle, a processor strobe never writes on its start edge, a gated processor strobe and sleep both freeze the address and the live state, a deselect start mutes the bus, the counter steps exactly once per advance, and an undriven bus reads as zero. The bench scenarios are needed for the properties that depend on stored contents and on address order. These are the interleaved and linear sequences from every start offset, per-lane masking, the survival of data through deselected and sleeping writes, strobe priority, and the immediate reaction of the outputs to the output enable and sleep inputs.

// File: rtl/burst_sram_fe_pkg.sv
package burst_sram_fe_pkg;

  localparam int BEAT_BITS = 2;

  typedef enum logic [1:0] {
    START_NONE = 2'd0,
    START_PROC = 2'd1,
    START_CTRL = 2'd2
  } start_kind_e;

  // low address bits of a burst word from its start bits and beat count
  function automatic logic [BEAT_BITS-1:0] beat_low(
    input logic [BEAT_BITS-1:0] base,
    input logic [BEAT_BITS-1:0] cnt,
    input logic                 interleave
  );
    return interleave ? (base ^ cnt) : (base + cnt);
  endfunction

endpackage

// File: rtl/burst_sram_fe_ctr.sv
module burst_sram_fe_ctr
  import burst_sram_fe_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [BEAT_BITS-1:0] load_low,
  input  logic                 step,
  input  logic                 interleave,
  output logic [BEAT_BITS-1:0] cur_low,
  output logic [BEAT_BITS-1:0] nxt_low
);

  logic [BEAT_BITS-1:0] base_q, base_d;
  logic [BEAT_BITS-1:0] cnt_q, cnt_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = load_low;
      cnt_d  = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cur_low = beat_low(base_q, cnt_q, interleave);
  assign nxt_low = beat_low(base_d, cnt_d, interleave);

  // R2: one advance moves the beat count by exactly one
  a_r2_step_once: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R2: no advance and no load keeps the burst position
  a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> ($stable(cnt_q) && $stable(base_q)));

  // R1: a load restarts the count at the captured low bits
  a_r1_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == '0 && base_q == $past(load_low)));

endmodule

// File: rtl/burst_sram_fe_wdec.sv
module burst_sram_fe_wdec #(
  parameter int LANES = 2
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             allow,
  output logic [LANES-1:0] lane_we
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = allow && (!gw_n || (!bwe_n && !bw_n[i]));
  end

endmodule

// File: rtl/burst_sram_fe_array.sv
module burst_sram_fe_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we[i]) store[waddr] <= wdata[i*LANE_W +: LANE_W];
    end

    assign rdata[i*LANE_W +: LANE_W] = store[raddr];
  end

endmodule

// File: rtl/burst_sram_fe.sv
module burst_sram_fe
  import burst_sram_fe_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  input  logic                    zz,
  input  logic                    burst_mode,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_drive
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int HIGH_W = ADDR_W - BEAT_BITS;

  start_kind_e          start_kind;
  logic                 start, ce_ok, step, wr_allow;
  logic                 live_q, wrote_q;
  logic [HIGH_W-1:0]    high_q, high_d;
  logic [BEAT_BITS-1:0] cur_low, nxt_low;
  logic [LANES-1:0]     lane_we;
  logic [ADDR_W-1:0]    raddr, waddr;
  logic [DATA_W-1:0]    arr_rdata;

  assign ce_ok = !ce1_n && ce2 && !ce3_n;

  // processor strobe needs ce1_n low and wins over the controller strobe
  always_comb begin
    start_kind = START_NONE;
    if (!zz && !adsp_n && !ce1_n)  start_kind = START_PROC;
    else if (!zz && !adsc_n)       start_kind = START_CTRL;
  end

  assign start    = (start_kind != START_NONE);
  assign step     = !zz && !start && live_q && !adv_n;
  assign wr_allow = !zz && (((start_kind == START_CTRL) && ce_ok) || (!start && live_q));
  assign high_d   = start ? addr_i[ADDR_W-1:BEAT_BITS] : high_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q  <= 1'b0;
      wrote_q <= 1'b0;
      high_q  <= '0;
    end else begin
      if (start) live_q <= ce_ok;
      if (!zz)   wrote_q <= |lane_we;
      high_q <= high_d;
    end
  end

  burst_sram_fe_ctr u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .load_low   (addr_i[BEAT_BITS-1:0]),
    .step       (step),
    .interleave (burst_mode),
    .cur_low    (cur_low),
    .nxt_low    (nxt_low)
  );

  burst_sram_fe_wdec #(.LANES(LANES)) u_wdec (
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bw_n    (bw_n),
    .allow   (wr_allow),
    .lane_we (lane_we)
  );

  assign raddr = {high_q, cur_low};
  assign waddr = {high_d, nxt_low};

  burst_sram_fe_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .we    (lane_we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (arr_rdata)
  );

  assign rdata_drive = live_q && !wrote_q && !oe_n && !zz;
  assign rdata       = rdata_drive ? arr_rdata : '0;

  // R9: the cycle after a writing edge leaves the bus undriven
  a_r9_write_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |=> !rdata_drive);

  // R8: a processor strobe start edge writes nothing
  a_r8_proc_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && !adsp_n && !ce1_n) |-> (lane_we == '0));

  // R5: a gated processor strobe with nothing else active changes nothing
  a_r5_proc_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && ce1_n && adsc_n && adv_n) |=> ($stable(raddr) && $stable(live_q)));

  // R6: a start with a failed select leaves the next cycle undriven
  a_r6_deselect_mutes: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ce_ok) |=> !rdata_drive);

  // R11: sleep freezes the burst position and live state
  a_r11_sleep_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> ($stable(raddr) && $stable(live_q)));

  // R4: advancing never touches the upper address bits
  a_r4_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> $stable(high_q));

  // R12: an undriven bus reads as zero
  a_r12_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_drive |-> (rdata == '0));

endmodule

// File: tb/burst_sram_fe_test.sv
`timescale 1ns/1ps
module burst_sram_fe_test;

  localparam int AW = 6;
  localparam int DW = 18;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic          gw_n = 1'b1, bwe_n = 1'b1;
  logic [1:0]    bw_n = 2'b11;
  logic [DW-1:0] wdata = '0;
  logic          oe_n = 1'b0, zz = 1'b0, burst_mode = 1'b0;
  logic [DW-1:0] rdata;
  logic          rdata_drive;

  logic [DW-1:0] ref_mem [DEPTH];
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  burst_sram_fe uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .wdata(wdata), .oe_n(oe_n), .zz(zz),
    .burst_mode(burst_mode), .rdata(rdata), .rdata_drive(rdata_drive)
  );

  function automatic logic [1:0] exp_low(input logic [1:0] base, input int k, input logic mode);
    logic [1:0] kk;
    kk = 2'(k);
    return mode ? (base ^ kk) : (base + kk);
  endfunction

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] a, input int k, input logic mode);
    return {a[AW-1:2], exp_low(a[1:0], k, mode)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = 2'b11;
    oe_n = 1'b0; zz = 1'b0;
  endtask

  // expected lane mask from write controls (R7)
  function automatic logic [1:0] lane_mask(input logic g, input logic be, input logic [1:0] b);
    if (!g) return 2'b11;
    if (!be) return ~b;
    return 2'b00;
  endfunction

  task automatic model_write(input logic [AW-1:0] a, input logic [1:0] m, input logic [DW-1:0] d);
    if (m[0]) ref_mem[a][8:0]  = d[8:0];
    if (m[1]) ref_mem[a][17:9] = d[17:9];
  endtask

  task automatic rand_ctrl(input bit full);
    if (full) begin
      gw_n = 1'b0; bwe_n = 1'b1; bw_n = 2'b11;
    end else begin
      gw_n = ($urandom % 4) != 0;
      bwe_n = $urandom % 2;
      bw_n = 2'($urandom);
    end
    wdata = DW'($urandom);
  endtask

  // controller-strobe burst: every beat may write (R8, R7, R9, R2)
  task automatic wr_burst(input logic [AW-1:0] a, input logic mode, input bit stalls, input bit full);
    logic [1:0] m;
    logic [AW-1:0] cur;
    quiet();
    burst_mode = mode;
    adsc_n = 1'b0; addr_i = a;
    rand_ctrl(full);
    m = lane_mask(gw_n, bwe_n, bw_n);
    tick();
    model_write(a, m, wdata);
    cur = a;
    if (m != 0) chk("R9 write cycle undriven", 32'(rdata_drive), 32'd0);
    else        chk("R1 controller start read", 32'(rdata), 32'(ref_mem[a]));
    adsc_n = 1'b1;
    for (int k = 1; k < 4; k++) begin
      if (stalls && ($urandom % 3 == 0)) begin
        adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1;
        tick();
        chk("R9 non-writing edge reads", 32'(rdata_drive), 32'd1);
        chk("R2 stall holds address", 32'(rdata), 32'(ref_mem[cur]));
      end
      adv_n = 1'b0;
      rand_ctrl(full);
      m = lane_mask(gw_n, bwe_n, bw_n);
      cur = beat_addr(a, k, mode);
      tick();
      model_write(cur, m, wdata);
      if (m != 0) chk("R8 continuation write floats", 32'(rdata_drive), 32'd0);
      else        chk("R7 no lane read beat", 32'(rdata), 32'(ref_mem[cur]));
    end
    quiet();
  endtask

  // processor-strobe burst with write controls held active on the start edge
  task automatic rd_burst(input logic [AW-1:0] a, input logic mode, input bit stalls);
    logic [AW-1:0] cur;
    quiet();
    burst_mode = mode;
    adsp_n = 1'b0; addr_i = a; gw_n = 1'b0; wdata = DW'($urandom);
    tick();
    chk("R8 proc start is read", 32'(rdata_drive), 32'd1);
    chk("R1 first word", 32'(rdata), 32'(ref_mem[a]));
    adsp_n = 1'b1; gw_n = 1'b1;
    for (int k = 1; k < 4; k++) begin
      if (stalls && ($urandom % 2 == 0)) begin
        adv_n = 1'b1;
        tick();
        chk("R2 stall keeps word", 32'(rdata), 32'(ref_mem[beat_addr(a, k - 1, mode)]));
      end
      adv_n = 1'b0;
      cur = beat_addr(a, k, mode);
      tick();
      if (mode) chk("R3 interleaved beat", 32'(rdata), 32'(ref_mem[cur]));
      else      chk("R4 linear beat", 32'(rdata), 32'(ref_mem[cur]));
    end
    quiet();
  endtask

  initial begin
    logic [AW-1:0] a, b;
    void'($urandom(32'd1729));
    quiet();
    rst_n = 1'b0;
    tick(); tick();
    chk("R12 reset no drive", 32'(rdata_drive), 32'd0);
    chk("R12 reset zero data", 32'(rdata), 32'd0);
    tick();
    rst_n = 1'b1;

    // fill whole array with linear full-word controller bursts
    for (int blk = 0; blk < DEPTH / 4; blk++) wr_burst(AW'(blk * 4), 1'b0, 1'b0, 1'b1);

    // every start offset, both orders
    for (int md = 0; md < 2; md++)
      for (int off = 0; off < 4; off++)
        rd_burst({AW'($urandom) & ~AW'(3)} | AW'(off), md[0], 1'b1);

    // R7 lane masking, directed
    a = 6'd13;
    quiet(); adsc_n = 1'b0; addr_i = a; bwe_n = 1'b0; bw_n = 2'b10; wdata = 18'h2A5A5;
    tick(); model_write(a, 2'b01, wdata);
    adsc_n = 1'b1; bwe_n = 1'b1; bw_n = 2'b00; wdata = 18'h3FFFF;
    tick();
    chk("R7 lane0 only written", 32'(rdata), 32'(ref_mem[a]));
    quiet(); adsc_n = 1'b0; addr_i = a; gw_n = 1'b1; bwe_n = 1'b0; bw_n = 2'b01; wdata = 18'h15A5A;
    tick(); model_write(a, 2'b10, wdata);
    quiet(); tick();
    chk("R7 lane1 only written", 32'(rdata), 32'(ref_mem[a]));

    // R5 gated processor strobe ignored
    a = 6'd20; b = 6'd41;
    rd_burst(a, 1'b0, 1'b0);
    adsp_n = 1'b0; ce1_n = 1'b1; addr_i = b;
    tick();
    chk("R5 gated proc strobe ignored", 32'(rdata), 32'(ref_mem[beat_addr(a, 3, 1'b0)]));
    // R5 controller strobe accepted with ce1_n high -> deselected cycle
    adsc_n = 1'b0;
    tick();
    chk("R5 ctrl strobe taken regardless", 32'(rdata_drive), 32'd0);
    // R5 priority: proc strobe wins, no write on start edge
    quiet(); adsp_n = 1'b0; adsc_n = 1'b0; addr_i = b; gw_n = 1'b0; wdata = 18'h00001;
    tick();
    chk("R5 proc strobe priority", 32'(rdata), 32'(ref_mem[b]));

    // R6 deselected cycle: no drive, no writes
    quiet(); adsc_n = 1'b0; ce2 = 1'b0; addr_i = a; gw_n = 1'b0; wdata = 18'h0BEEF;
    tick();
    chk("R6 deselect no drive", 32'(rdata_drive), 32'd0);
    adsc_n = 1'b1; ce2 = 1'b1; adv_n = 1'b0;
    tick();
    chk("R6 deselect burst no drive", 32'(rdata_drive), 32'd0);
    rd_burst(a, 1'b0, 1'b0);
    quiet(); ce3_n = 1'b1; adsp_n = 1'b1; adsc_n = 1'b0; addr_i = a; gw_n = 1'b0;
    tick();
    chk("R6 ce3_n high deselects", 32'(rdata_drive), 32'd0);

    // R10 asynchronous output enable
    quiet(); adsp_n = 1'b0; addr_i = b;
    tick();
    adsp_n = 1'b1; oe_n = 1'b1; #1;
    chk("R10 oe_n high undriven", 32'(rdata_drive), 32'd0);
    chk("R12 undriven reads zero", 32'(rdata), 32'd0);
    oe_n = 1'b0; #1;
    chk("R10 oe_n low drives again", 32'(rdata), 32'(ref_mem[b]));

    // R11 sleep
    zz = 1'b1; #1;
    chk("R11 sleep undriven", 32'(rdata_drive), 32'd0);
    adsc_n = 1'b0; addr_i = a; gw_n = 1'b0; adv_n = 1'b0; wdata = 18'h1CAFE;
    tick(); tick();
    adsc_n = 1'b1; gw_n = 1'b1; adv_n = 1'b1; zz = 1'b0; #1;
    chk("R11 state kept through sleep", 32'(rdata), 32'(ref_mem[b]));
    rd_burst(a, 1'b1, 1'b0);

    // constrained random traffic
    for (int it = 0; it < 150; it++) begin
      logic m;
      a = AW'($urandom);
      m = $urandom % 2;
      wr_burst(a, m, 1'b1, 1'b0);
      rd_burst(a, m, 1'b1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule